// File: doc/BRIEF.md
# Single-Cycle 32-Bit Processor Core

This block is a small processor core that completes one instruction on every rising clock edge. It supports register-to-register arithmetic and logic, load word, store word, branch-if-equal and an absolute jump. It holds the program counter, a register file, an ALU with its operation decoder, an opcode decoder, and the next-address logic. The instruction memory and the data memory are small word arrays inside the block.

A test load port writes words into either memory, normally while reset is held. Two combinational debug read ports show any register and any data memory word. The program counter is brought out as a port.

Instruction fields are fixed: opcode in bits [31:26], first source register in [25:21], second source register in [20:16], R-type destination in [15:11], function code in [5:0], the 16-bit immediate in [15:0], and the 26-bit jump field in [25:0].

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous, active high), the PC becomes 0 and every register reads 0 from then on, until it is written again.
- R2: An instruction that is neither a taken branch nor a jump moves the PC to PC + 4 at the next edge. Instructions are fetched from word index PC[IAW+1:2].
- R3: Opcode 0x00 is R-type. The function code in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. Set-less-than is a signed compare that gives 1 or 0. The result is written to the register named by bits [15:11].
- R4: Opcode 0x23 (load word) reads the data word at byte address (register[25:21] + sign-extended bits [15:0]). That word goes to word index address[DAW+1:2] and is written to the register named by bits [20:16].
- R5: Opcode 0x2B (store word) writes the register named by bits [20:16] to the data word at the same kind of address as R4. It writes no register.
- R6: Opcode 0x04 (branch-if-equal) compares the two source registers. If they are equal, the PC becomes PC + 4 + (sign-extended offset × 4). If they differ, the PC becomes PC + 4.
- R7: Opcode 0x02 (jump) sets the PC to {(PC+4)[31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads 0. A write that names register 0 has no effect.
- R9: Any other opcode writes neither a register nor data memory, and the PC advances by 4.
- R10: While `load_we` is high, the word on `load_data` is written at the edge to index `load_addr`. The target is data memory when `load_to_dmem` is 1 and instruction memory when it is 0. The debug ports show `dbg_reg_sel`'s register and `dbg_mem_addr`'s data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Test load write strobe |
| load_to_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr | input | LAW | Word index for the test load |
| load_data | input | XLEN | Word to load |
| dbg_reg_sel | input | 5 | Register to show on `dbg_reg_data` |
| dbg_reg_data | output | XLEN | Selected register value |
| dbg_mem_addr | input | DAW | Data memory word index to show |
| dbg_mem_data | output | XLEN | Selected data memory word |
| pc | output | XLEN | Current program counter |

## Verification
The hardest case to reach from the ports is an instruction whose effect must be absent. Three cases need this: the instructions skipped by a taken branch or by a jump, an unknown opcode, and a write to register 0. None of them can be seen directly. The stimulus handles this with a preloaded program. The skipped slots and the bad opcode are placed so that they would overwrite registers or memory words that already hold known non-zero values. After the run, those registers and words are read back through the debug ports. A negative load offset and a signed compare against a negative operand are also part of the program, so sign extension shows up in the final register values.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BREQ  = 6'h04;
   localparam logic [5:0] OPC_JUMP  = 6'h02;

   localparam logic [5:0] FC_ADD = 6'h20;
   localparam logic [5:0] FC_SUB = 6'h22;
   localparam logic [5:0] FC_AND = 6'h24;
   localparam logic [5:0] FC_OR  = 6'h25;
   localparam logic [5:0] FC_SLT = 6'h2A;

   typedef enum logic [1:0] {
      AOP_ADD   = 2'b00,
      AOP_SUB   = 2'b01,
      AOP_FUNCT = 2'b10
   } alu_op_t;

   typedef enum logic [2:0] {
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT
   } alu_fn_t;

   // the seven decoder outputs plus the ALU operation class and the jump select
   typedef struct packed {
      logic    dst_from_rd;
      logic    b_from_imm;
      logic    wb_from_mem;
      logic    rf_write;
      logic    dm_read;
      logic    dm_write;
      logic    is_branch;
      logic    is_jump;
      alu_op_t alu_op;
   } ctrl_t;

endpackage

// File: rtl/onecyc_decoder.sv
module onecyc_decoder
   import onecyc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (opcode)
         OPC_RTYPE: begin
            ctrl.dst_from_rd = 1'b1;
            ctrl.rf_write    = 1'b1;
            ctrl.alu_op      = AOP_FUNCT;
         end
         OPC_LOAD: begin
            ctrl.b_from_imm  = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.rf_write    = 1'b1;
            ctrl.dm_read     = 1'b1;
            ctrl.alu_op      = AOP_ADD;
         end
         OPC_STORE: begin
            ctrl.b_from_imm  = 1'b1;
            ctrl.dm_write    = 1'b1;
            ctrl.alu_op      = AOP_ADD;
         end
         OPC_BREQ: begin
            ctrl.is_branch   = 1'b1;
            ctrl.alu_op      = AOP_SUB;
         end
         OPC_JUMP: begin
            ctrl.is_jump     = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
   import onecyc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  alu_op_t           op,
   input  logic [5:0]        funct,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   output logic [XLEN-1:0]   y,
   output logic              zero
);

   alu_fn_t fn;
   logic    lt;

   always_comb begin
      fn = FN_ADD;
      case (op)
         AOP_ADD: fn = FN_ADD;
         AOP_SUB: fn = FN_SUB;
         default: begin
            case (funct)
               FC_SUB:  fn = FN_SUB;
               FC_AND:  fn = FN_AND;
               FC_OR:   fn = FN_OR;
               FC_SLT:  fn = FN_SLT;
               default: fn = FN_ADD;
            endcase
         end
      endcase
   end

   generate
      if (SLT_SIGNED) begin : g_lt_signed
         assign lt = $signed(a) < $signed(b);
      end else begin : g_lt_unsigned
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_SLT:  y = {{(XLEN-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [RAW-1:0]  ra_addr,
   output logic [XLEN-1:0] ra_data,
   input  logic [RAW-1:0]  rb_addr,
   output logic [XLEN-1:0] rb_data,
   input  logic [RAW-1:0]  rc_addr,
   output logic [XLEN-1:0] rc_data,
   input  logic            wr_en,
   input  logic [RAW-1:0]  wr_addr,
   input  logic [XLEN-1:0] wr_data
);

   logic [XLEN-1:0] q [1:NREG-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 1; i < NREG; i++) q[i] <= '0;
      end else if (wr_en && wr_addr != '0) begin
         q[wr_addr] <= wr_data;
      end
   end

   assign ra_data = (ra_addr == '0) ? '0 : q[ra_addr];
   assign rb_data = (rb_addr == '0) ? '0 : q[rb_addr];
   assign rc_data = (rc_addr == '0) ? '0 : q[rc_addr];

   // R3
   rf_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0) |=> (q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
   import onecyc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter bit SLT_SIGNED = 1'b1,
   localparam int IAW = $clog2(IMEM_WORDS),
   localparam int DAW = $clog2(DMEM_WORDS),
   localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_we,
   input  logic            load_to_dmem,
   input  logic [LAW-1:0]  load_addr,
   input  logic [XLEN-1:0] load_data,
   input  logic [4:0]      dbg_reg_sel,
   output logic [XLEN-1:0] dbg_reg_data,
   input  logic [DAW-1:0]  dbg_mem_addr,
   output logic [XLEN-1:0] dbg_mem_data,
   output logic [XLEN-1:0] pc
);

   initial begin
      assert (XLEN == 32) else $error("onecyc_core: XLEN must be 32");
      assert (NREG == 32) else $error("onecyc_core: NREG must be 32");
      assert (IMEM_WORDS >= 4 && (1 << IAW) == IMEM_WORDS)
         else $error("onecyc_core: IMEM_WORDS must be a power of two >= 4");
      assert (DMEM_WORDS >= 4 && (1 << DAW) == DMEM_WORDS)
         else $error("onecyc_core: DMEM_WORDS must be a power of two >= 4");
   end

   logic [XLEN-1:0] pc_q, pc_nxt, pc_seq, br_tgt, jmp_tgt;
   logic [XLEN-1:0] instr, imm_sx;
   logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
   logic [4:0]      wr_sel;
   logic            alu_zero, take_br, rf_we, dm_we;
   logic [DAW-1:0]  dm_idx;
   ctrl_t           ctrl;

   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   // fetch
   assign instr = imem[pc_q[IAW+1:2]];

   always_ff @(posedge clk) begin
      if (load_we && !load_to_dmem) imem[load_addr[IAW-1:0]] <= load_data;
   end

   onecyc_decoder u_dec (
      .opcode (instr[31:26]),
      .ctrl   (ctrl)
   );

   assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
   assign wr_sel = ctrl.dst_from_rd ? instr[15:11] : instr[20:16];
   assign rf_we  = ctrl.rf_write && !rst;

   onecyc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .ra_addr (instr[25:21]),
      .ra_data (rs_val),
      .rb_addr (instr[20:16]),
      .rb_data (rt_val),
      .rc_addr (dbg_reg_sel),
      .rc_data (dbg_reg_data),
      .wr_en   (rf_we),
      .wr_addr (wr_sel),
      .wr_data (wb_data)
   );

   assign alu_b = ctrl.b_from_imm ? imm_sx : rt_val;

   onecyc_alu #(.XLEN(XLEN), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .op    (ctrl.alu_op),
      .funct (instr[5:0]),
      .a     (rs_val),
      .b     (alu_b),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   // data memory
   assign dm_idx   = alu_y[DAW+1:2];
   assign dm_rdata = dmem[dm_idx];
   assign dm_we    = ctrl.dm_write && !rst;
   assign wb_data  = ctrl.wb_from_mem ? dm_rdata : alu_y;

   always_ff @(posedge clk) begin
      if (load_we && load_to_dmem) dmem[load_addr[DAW-1:0]] <= load_data;
      else if (dm_we)              dmem[dm_idx] <= rt_val;
   end

   assign dbg_mem_data = dmem[dbg_mem_addr];

   // next PC
   assign pc_seq  = pc_q + XLEN'(4);
   assign br_tgt  = pc_seq + {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_tgt = {pc_seq[31:28], instr[25:0], 2'b00};
   assign take_br = ctrl.is_branch && alu_zero;

   always_comb begin
      if (ctrl.is_jump)  pc_nxt = jmp_tgt;
      else if (take_br)  pc_nxt = br_tgt;
      else               pc_nxt = pc_seq;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_nxt;
   end

   assign pc = pc_q;

   logic unused_sink;
   assign unused_sink = ^{pc_q, alu_y, load_addr, ctrl.dm_read};

   logic op_known;
   assign op_known = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h23) ||
                     (instr[31:26] == 6'h2B) || (instr[31:26] == 6'h04) ||
                     (instr[31:26] == 6'h02);

   // R1
   rst_pc_zero_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctrl.is_jump && !(ctrl.is_branch && alu_zero)) |=> (pc_q == $past(pc_q) + XLEN'(4)));

   // R6
   br_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl.is_branch && (rs_val == rt_val)) |=> (pc_q == $past(br_tgt)));

   // R7
   jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl.is_jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

   // R9
   bad_op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !op_known |-> (!rf_we && !dm_we && !ctrl.is_branch && !ctrl.is_jump));

endmodule

// File: tb/onecyc_core_tb_top.sv
module onecyc_core_tb_top;

   localparam int LAW = 6;
   localparam int DAW = 6;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            load_we = 1'b0;
   logic            load_to_dmem = 1'b0;
   logic [LAW-1:0]  load_addr = '0;
   logic [31:0]     load_data = '0;
   logic [4:0]      dbg_reg_sel = '0;
   logic [31:0]     dbg_reg_data;
   logic [DAW-1:0]  dbg_mem_addr = '0;
   logic [31:0]     dbg_mem_data;
   logic [31:0]     pc;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   onecyc_core dut_i (
      .clk          (clk),
      .rst          (rst),
      .load_we      (load_we),
      .load_to_dmem (load_to_dmem),
      .load_addr    (load_addr),
      .load_data    (load_data),
      .dbg_reg_sel  (dbg_reg_sel),
      .dbg_reg_data (dbg_reg_data),
      .dbg_mem_addr (dbg_mem_addr),
      .dbg_mem_data (dbg_mem_data),
      .pc           (pc)
   );

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, rs[4:0], rt[4:0], imm};
   endfunction

   function automatic logic [31:0] enc_j(logic [25:0] tgt);
      return {6'h02, tgt};
   endfunction

   // expected register contents after the program: {req, reg, value}
   localparam int NEXP = 16;
   localparam logic [40:0] EXP_TAB [NEXP] = '{
      {4'd4,  5'd1,  32'd7},          // R4 load
      {4'd4,  5'd2,  32'd5},
      {4'd4,  5'd3,  32'hFFFF_FFF0},
      {4'd3,  5'd4,  32'd12},         // R3 add
      {4'd3,  5'd5,  32'd2},          // sub
      {4'd3,  5'd6,  32'd5},          // and
      {4'd3,  5'd7,  32'd7},          // or
      {4'd3,  5'd8,  32'd1},          // slt, negative < positive
      {4'd3,  5'd9,  32'd0},          // slt, positive vs negative
      {4'd5,  5'd10, 32'd12},         // R5 stored then reloaded
      {4'd8,  5'd0,  32'd0},          // R8 write to r0 ignored
      {4'd6,  5'd11, 32'd0},          // R6 slots skipped by taken branch
      {4'd7,  5'd12, 32'd0},          // R7 slots skipped by jump
      {4'd9,  5'd13, 32'd0},          // R9
      {4'd4,  5'd14, 32'hFFFF_FFF0},  // negative offset
      {4'd4,  5'd15, 32'h1234_5678}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_word(logic to_d, int idx, logic [31:0] w);
      @(negedge clk);
      load_we      = 1'b1;
      load_to_dmem = to_d;
      load_addr    = idx[LAW-1:0];
      load_data    = w;
      @(negedge clk);
      load_we      = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
   end

   initial begin : main
      logic [31:0] prog [23];
      prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
      prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
      prog[2]  = enc_i(6'h23, 0, 3, 16'd8);
      prog[3]  = enc_r(1, 2, 4, 6'h20);
      prog[4]  = enc_r(1, 2, 5, 6'h22);
      prog[5]  = enc_r(1, 2, 6, 6'h24);
      prog[6]  = enc_r(1, 2, 7, 6'h25);
      prog[7]  = enc_r(3, 1, 8, 6'h2A);
      prog[8]  = enc_r(1, 3, 9, 6'h2A);
      prog[9]  = enc_i(6'h2B, 0, 4, 16'd16);
      prog[10] = enc_i(6'h23, 0, 10, 16'd16);
      prog[11] = enc_r(1, 2, 0, 6'h20);
      prog[12] = enc_i(6'h04, 1, 2, 16'd5);
      prog[13] = enc_i(6'h04, 1, 7, 16'd2);
      prog[14] = enc_r(1, 1, 11, 6'h20);
      prog[15] = enc_r(1, 1, 11, 6'h20);
      prog[16] = enc_j(26'd19);
      prog[17] = enc_r(1, 1, 12, 6'h20);
      prog[18] = enc_r(1, 1, 12, 6'h20);
      prog[19] = enc_i(6'h3F, 0, 2, 16'd0);
      prog[20] = enc_i(6'h23, 4, 14, 16'hFFFC);
      prog[21] = enc_i(6'h23, 0, 15, 16'd12);
      prog[22] = enc_i(6'h04, 0, 0, 16'hFFFF);

      rst = 1'b1;
      for (int i = 0; i < 23; i++) load_word(1'b0, i, prog[i]);
      load_word(1'b1, 0, 32'd7);
      load_word(1'b1, 1, 32'd5);
      load_word(1'b1, 2, 32'hFFFF_FFF0);
      load_word(1'b1, 3, 32'h1234_5678);
      load_word(1'b1, 4, 32'hDEAD_BEEF);

      // R10 load port and debug read of data memory
      dbg_mem_addr = 6'd3;
      #1 check("R10", dbg_mem_data, 32'h1234_5678, "preloaded data word");
      // R1 PC held at zero under reset
      check("R1", pc, 32'd0, "pc during reset");

      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R2", pc, 32'd4, "pc one edge after reset release");
      @(negedge clk);
      check("R2", pc, 32'd8, "pc two edges after reset release");

      repeat (40) @(negedge clk);

      for (int k = 0; k < NEXP; k++) begin
         dbg_reg_sel = EXP_TAB[k][36:32];
         #1;
         check($sformatf("R%0d", EXP_TAB[k][40:37]), dbg_reg_data, EXP_TAB[k][31:0],
               $sformatf("register %0d", EXP_TAB[k][36:32]));
      end

      dbg_mem_addr = 6'd4;
      #1 check("R5", dbg_mem_data, 32'd12, "stored word");
      dbg_mem_addr = 6'd0;
      #1 check("R9", dbg_mem_data, 32'd7, "data word untouched by unknown opcode");
      check("R6", pc, 32'd88, "pc parked on self branch");
      @(negedge clk);
      check("R6", pc, 32'd88, "self branch keeps pc");

      // R1 reset clears registers and PC
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1", pc, 32'd0, "pc after reset pulse");
      dbg_reg_sel = 5'd1;
      #1 check("R1", dbg_reg_data, 32'd0, "register 1 after reset");
      dbg_reg_sel = 5'd15;
      #1 check("R1", dbg_reg_data, 32'd0, "register 15 after reset");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule